// File: doc/BRIEF.md
# Channel status and user bit collector

This block sits behind a receiver that has already recovered the subframes of a two-channel digital audio stream. For every recovered subframe it is given a strobe, a flag telling whether the subframe belongs to the first (A) or second (B) channel, a flag that marks the first frame of a status block, and the two side-band bits of that subframe: the channel-status bit and the user bit. It assembles these bits into a single status word that software or a neighbouring block can read.

One capture spans eight frames, which is sixteen subframes that alternate A, B, A, B. The eight channel-status bits of the A subframes fill one field. All sixteen user bits fill a second field, with A bits at even positions and B bits at odd positions. A flag records whether the first status bit of the capture opened a new block. When the last B subframe of a capture arrives, the word is latched into the output register and a ready strobe is pulsed for one cycle. Collection then continues straight into the next capture.

Alignment is always taken from an A subframe. B subframes seen while the collector is idle are dropped. A break in the A/B alternation restarts or abandons the capture in progress. A synchronous clear abandons the capture in progress and leaves the last latched word in place.

Top module: `cu_status_collector`

## Requirements
- R1: After reset, `status_o` is all zeros and `ready_o` is low.
- R2: Bits 31:25 of `status_o` are always zero.
- R3: Bits 23:16 of `status_o` hold the channel-status bits of the eight A subframes of a capture. Bit 16 holds the oldest of them and bit 23 the newest. Channel-status bits of B subframes are never stored.
- R4: Bits 15:0 of `status_o` hold the sixteen user bits of a capture in arrival order. Bit 0 holds the oldest. Even positions come from A subframes and odd positions from B subframes.
- R5: Bit 24 of `status_o` equals the block-start flag of the A subframe that supplied bit 16.
- R6: A B subframe that arrives while no capture is in progress is ignored. A capture always begins with an A subframe.
- R7: `ready_o` is high for exactly one cycle, in the cycle after the clock edge at which the sixteenth subframe of a capture is accepted. `status_o` takes the new word in that same cycle and holds its value in every other cycle.
- R8: While `sf_valid_i` is low, the values on `sf_is_a_i`, `sf_blk_i`, `sf_c_i` and `sf_u_i` have no effect.
- R9: When `clr_i` is high at a clock edge, any subframe presented in that cycle is ignored and the capture in progress is dropped. `status_o` keeps its value. The next capture begins at the next A subframe.
- R10: An A subframe arriving where a B subframe is expected restarts the capture, with that A subframe as its first. A B subframe arriving where an A subframe is expected drops the capture, and the collector waits for the next A subframe.
- R11: After a capture completes, the next accepted A subframe begins a new capture with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the capture in progress |
| sf_valid_i | input | 1 | One recovered subframe is presented this cycle |
| sf_is_a_i | input | 1 | 1 for a channel A subframe, 0 for channel B |
| sf_blk_i | input | 1 | Subframe belongs to the first frame of a status block |
| sf_c_i | input | 1 | Channel-status bit of the subframe |
| sf_u_i | input | 1 | User bit of the subframe |
| status_o | output | 32 | Latched status word: bit 24 start-of-block flag, 23:16 status bits, 15:0 user bits |
| ready_o | output | 1 | One-cycle pulse when a new word is latched |

## Verification
Every cycle, the assertions check that the reserved bits stay zero and that the ready strobe never lasts two cycles. They also check that the word changes only together with the strobe, that each strobe follows an accepted B subframe, and that a clear is never followed by a strobe. Only the bench scenarios can show that the bits land in the right order and at the right positions. The same holds for the start-of-block flag following the first A subframe, for leading B subframes being dropped, for invalid strobes carrying junk being ignored, for broken alternation restarting or abandoning a capture, and for back-to-back captures producing the expected sequence of words.

// File: rtl/cu_collect_pkg.sv
package cu_collect_pkg;

  // Number of channel-status bits gathered per capture (one per A subframe).
  localparam int CS_BITS  = 8;
  // User bits per capture: one per subframe, both channels.
  localparam int USR_BITS = 2 * CS_BITS;
  // Width of the packed word: flag + status field + user field.
  localparam int WORD_BITS = 1 + CS_BITS + USR_BITS;
  // Width of the readable status port.
  localparam int OUT_BITS = 32;

  typedef struct packed {
    logic is_a;
    logic blk;
    logic c;
    logic u;
  } subframe_t;

endpackage

// File: rtl/cu_align_ctrl.sv
module cu_align_ctrl #(
  parameter int USR_W = 16,
  localparam int CNT_W = $clog2(USR_W)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic valid_i,
  input  logic is_a_i,
  output logic accept_o,
  output logic accept_a_o,
  output logic first_o,
  output logic done_o
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             expect_a;
  logic             accept, first, drop, done;

  // Even count means an A subframe comes next.
  assign expect_a = ~cnt_q[0];

  always_comb begin
    accept = 1'b0;
    first  = 1'b0;
    drop   = 1'b0;
    if (!clr_i && valid_i) begin
      if (!busy_q) begin
        if (is_a_i) begin
          accept = 1'b1;
          first  = 1'b1;
        end
      end else if (is_a_i == expect_a) begin
        accept = 1'b1;
      end else if (is_a_i) begin
        accept = 1'b1;
        first  = 1'b1;
      end else begin
        drop = 1'b1;
      end
    end
  end

  assign done = accept && !is_a_i && busy_q && (cnt_q == CNT_W'(USR_W - 1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (clr_i || done || drop) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (first) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(1);
    end else if (accept) begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign accept_o   = accept;
  assign accept_a_o = accept && is_a_i;
  assign first_o    = first;
  assign done_o     = done;

endmodule

// File: rtl/cu_shift_field.sv
module cu_shift_field #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] d_o
);

  logic [W-1:0] q, d;

  // New bit enters at the top; after W shifts the oldest sits at index 0.
  always_comb begin
    d = q;
    if (en_i) begin
      d = {bit_i, q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= d;
    end
  end

  assign q_o = q;
  assign d_o = d;

endmodule

// File: rtl/cu_word_latch.sv
module cu_word_latch #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o,
  output logic         strobe_o
);

  logic [W-1:0] word_q, word_d;
  logic         strobe_q;

  always_comb begin
    word_d = word_q;
    if (load_i) begin
      word_d = word_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      word_q   <= word_d;
      strobe_q <= load_i;
    end
  end

  assign word_o   = word_q;
  assign strobe_o = strobe_q;

endmodule

// File: rtl/cu_status_collector.sv
module cu_status_collector
  import cu_collect_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                sf_valid_i,
  input  logic                sf_is_a_i,
  input  logic                sf_blk_i,
  input  logic                sf_c_i,
  input  logic                sf_u_i,
  output logic [OUT_BITS-1:0] status_o,
  output logic                ready_o
);

  subframe_t sf;
  logic accept, accept_a, first, done;
  logic sob_q, sob_d;
  logic [CS_BITS-1:0]   cs_q, cs_d;
  logic [USR_BITS-1:0]  usr_q, usr_d;
  logic [WORD_BITS-1:0] word_next, word_q;

  assign sf = '{is_a: sf_is_a_i, blk: sf_blk_i, c: sf_c_i, u: sf_u_i};

  cu_align_ctrl #(.USR_W(USR_BITS)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .valid_i    (sf_valid_i),
    .is_a_i     (sf.is_a),
    .accept_o   (accept),
    .accept_a_o (accept_a),
    .first_o    (first),
    .done_o     (done)
  );

  // Status bits: A subframes only.
  cu_shift_field #(.W(CS_BITS)) i_cs_field (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (accept_a),
    .bit_i (sf.c),
    .q_o   (cs_q),
    .d_o   (cs_d)
  );

  // User bits: every accepted subframe, interleaved A then B.
  cu_shift_field #(.W(USR_BITS)) i_usr_field (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (accept),
    .bit_i (sf.u),
    .q_o   (usr_q),
    .d_o   (usr_d)
  );

  // Block-start flag of the subframe that opens the capture.
  always_comb begin
    sob_d = sob_q;
    if (first) begin
      sob_d = sf.blk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sob_q <= 1'b0;
    end else begin
      sob_q <= sob_d;
    end
  end

  assign word_next = {sob_q, cs_d, usr_d};

  cu_word_latch #(.W(WORD_BITS)) i_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (done),
    .word_i   (word_next),
    .word_o   (word_q),
    .strobe_o (ready_o)
  );

  assign status_o = {{(OUT_BITS - WORD_BITS){1'b0}}, word_q};

endmodule

// File: rtl/cu_status_collector_chk.sv
module cu_status_collector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr_i,
  input logic        sf_valid_i,
  input logic        sf_is_a_i,
  input logic [31:0] status_o,
  input logic        ready_o
);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[31:25] == 7'd0);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> $stable(status_o));

  assert_ready_after_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> $past(sf_valid_i && !sf_is_a_i && !clr_i));

  assert_clear_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_i) |-> !ready_o);

endmodule

bind cu_status_collector cu_status_collector_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_i      (clr_i),
  .sf_valid_i (sf_valid_i),
  .sf_is_a_i  (sf_is_a_i),
  .status_o   (status_o),
  .ready_o    (ready_o)
);

// File: tb/test_cu_status_collector.sv
module test_cu_status_collector;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0;
  logic        sf_valid_i = 1'b0;
  logic        sf_is_a_i = 1'b0;
  logic        sf_blk_i = 1'b0;
  logic        sf_c_i = 1'b0;
  logic        sf_u_i = 1'b0;
  logic [31:0] status_o;
  logic        ready_o;

  int checks = 0;
  int fails  = 0;
  logic [24:0] exp_q[$];
  logic        prev_ready = 1'b0;
  logic        done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cu_status_collector i_cu_status_collector (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .sf_valid_i(sf_valid_i),
    .sf_is_a_i(sf_is_a_i), .sf_blk_i(sf_blk_i), .sf_c_i(sf_c_i),
    .sf_u_i(sf_u_i), .status_o(status_o), .ready_o(ready_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one subframe for one cycle.
  task automatic send_sf(input bit a, input bit blk, input bit c, input bit u);
    @(negedge clk);
    sf_valid_i = 1'b1; sf_is_a_i = a; sf_blk_i = blk; sf_c_i = c; sf_u_i = u;
  endtask

  // Idle cycle with junk on the data pins (R8).
  task automatic junk_cycle(input bit a, input bit blk, input bit c, input bit u);
    @(negedge clk);
    sf_valid_i = 1'b0; sf_is_a_i = a; sf_blk_i = blk; sf_c_i = c; sf_u_i = u;
  endtask

  // Full capture; pushes the word the requirements predict (R3, R4, R5).
  task automatic send_capture(input bit sob, input logic [7:0] cs,
                              input logic [15:0] usr, input bit gaps);
    exp_q.push_back({sob, cs, usr});
    for (int k = 0; k < 16; k++) begin
      send_sf(k % 2 == 0, (k == 0) ? sob : ~sob, (k % 2 == 0) ? cs[k/2] : ~cs[k/2],
              usr[k]);
      if (gaps) junk_cycle(k % 2 != 0, 1'b1, 1'b1, ~usr[k]);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) junk_cycle(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // Monitor / scoreboard.
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (ready_o) begin
        chk(!prev_ready, "R7 pulse width", {31'd0, prev_ready}, 32'd0);
        chk(status_o[31:25] == 7'd0, "R2 reserved bits", status_o, {7'd0, status_o[24:0]});
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected ready", status_o, 32'd0);
        end else begin
          logic [24:0] e;
          e = exp_q.pop_front();
          chk(status_o[24] == e[24], "R5 start-of-block flag", {31'd0, status_o[24]}, {31'd0, e[24]});
          chk(status_o[23:16] == e[23:16], "R3 status field", {24'd0, status_o[23:16]}, {24'd0, e[23:16]});
          chk(status_o[15:0] == e[15:0], "R4 user field", {16'd0, status_o[15:0]}, {16'd0, e[15:0]});
        end
      end
      prev_ready = ready_o;
    end
  end

  initial begin
    #200000;
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk(status_o == 32'd0 && ready_o == 1'b0, "R1 reset state", status_o, 32'd0);
    rst_n = 1'b1;
    idle(2);

    // R6: leading B subframes ignored, then aligned capture.
    send_sf(1'b0, 1'b1, 1'b1, 1'b1);
    send_sf(1'b0, 1'b1, 1'b1, 1'b1);
    send_capture(1'b1, 8'hA5, 16'h3C96, 1'b0);
    idle(3);

    // R8: junk between valid subframes.
    send_capture(1'b0, 8'h5A, 16'hC369, 1'b1);
    idle(3);

    // R11: back-to-back captures.
    send_capture(1'b1, 8'h01, 16'h8001, 1'b0);
    send_capture(1'b0, 8'h80, 16'h7FFE, 1'b0);
    idle(3);

    // R10: extra A where B expected restarts the capture.
    send_sf(1'b1, 1'b0, 1'b1, 1'b1);
    send_capture(1'b1, 8'hF0, 16'h0F0F, 1'b0);
    idle(2);

    // R10: B where A expected drops the capture.
    send_sf(1'b1, 1'b1, 1'b1, 1'b1);
    send_sf(1'b0, 1'b1, 1'b1, 1'b1);
    send_sf(1'b0, 1'b1, 1'b1, 1'b1);
    send_capture(1'b0, 8'h3C, 16'hA55A, 1'b0);
    idle(3);

    // R9: clear mid-capture.
    held = status_o;
    for (int k = 0; k < 10; k++) send_sf(k % 2 == 0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    sf_valid_i = 1'b1; sf_is_a_i = 1'b0; clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0; sf_valid_i = 1'b0;
    chk(status_o == held, "R9 word held across clear", status_o, held);
    chk(ready_o == 1'b0, "R9 no ready after clear", {31'd0, ready_o}, 32'd0);
    // Remaining 6 subframes of the old capture must not complete it.
    for (int k = 0; k < 6; k++) send_sf(k % 2 == 0, 1'b1, 1'b1, 1'b1);
    send_sf(1'b0, 1'b1, 1'b0, 1'b0);
    idle(3);
    chk(status_o == held, "R9 partial capture dropped", status_o, held);
    send_capture(1'b1, 8'hC3, 16'h1234, 1'b0);
    idle(4);

    chk(exp_q.size() == 0, "R7 missing ready", exp_q.size(), 32'd0);
    chk(status_o == {7'd0, 1'b1, 8'hC3, 16'h1234}, "R7 word held after ready",
        status_o, {7'd0, 1'b1, 8'hC3, 16'h1234});
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule